// File: doc/BRIEF.md
# Programmable Reference Divider with Optional Half-Rate Toggle

This block sits in the reference path ahead of a phase-frequency detector. It is clocked by the incoming reference clock, counts that clock down by a programmable 10-bit ratio, and produces the comparison clock. In direct mode, the terminal count of the counter drives the comparison clock. In half-rate mode, a toggle flip-flop follows the counter. That halves the rate and gives the comparison clock an exact 50% duty cycle.

A hold control and a power-down control both force the counter back to its load state and silence the outputs. The divider settings presented on the inputs are kept through either one. When the outputs are released, the count restarts cleanly from the full ratio. A single-cycle event pulse marks the start of every output period. A ratio written while a count is running is picked up only when the counter next reloads.

Top module: `refdiv_top`

## Requirements
- R1: In direct mode (`half_en`=0) with an effective ratio N from 1 to 1023, `cmp_clk` repeats every N reference cycles and is high for exactly one cycle of each period. For N=1 it stays high.
- R2: In half-rate mode (`half_en`=1), `cmp_clk` repeats every 2N reference cycles. It is high for N cycles and low for N cycles of each period.
- R3: A `ratio` value of 0 behaves exactly as a ratio of 1.
- R4: While `cnt_hold`=1, `cmp_clk` and `cmp_pulse` are 0. After `cnt_hold` returns to 0, the first `cmp_pulse` appears after the (N+1)th rising reference edge, counting from the first edge at which the control is low.
- R5: `pwr_dn`=1 forces the same state as R4, including clearing the toggle flip-flop, so `cmp_clk` drops to 0 after one edge. On release, the output resumes with the unchanged settings and the same N+1 latency.
- R6: A new `ratio` applied just after an output event does not shorten the period that is already running. The old ratio sets the next period, and the new ratio applies from the period after it.
- R7: `cmp_pulse` is high for exactly one reference cycle per output period, in the cycle where `cmp_clk` rises. It is never high while `cmp_clk` is low.
- R8: While `rst_n`=0, both outputs are 0 regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio | input | 10 | Division ratio; 0 is treated as 1 |
| half_en | input | 1 | 1 selects the half-rate toggle stage |
| cnt_hold | input | 1 | 1 holds the counter in its load state |
| pwr_dn | input | 1 | 1 forces the load state and clears the toggle stage |
| cmp_clk | output | 1 | Divided comparison clock |
| cmp_pulse | output | 1 | One-cycle pulse at each rising edge of cmp_clk |

## Verification
The bench aims at the extremes of the ratio: 0, 1 and 1023, in both modes. A divider that decodes 0 as 1024, or that drops a cycle on reload, shows the wrong period. It measures the latency from releasing hold or power-down. An off-by-one in the load value, or a counter that resumes from a stale count, shifts that latency. It changes the ratio right after an output event. A design that loads the ratio mid-count cuts the running period short. It also drops power-down while the toggle output is high, which exposes a toggle stage that keeps its phase.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned RATIO_W = 10;

  // Ratio actually used by the counter: 0 is promoted to 1.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [RATIO_W-1:0] r);
    return (r == '0) ? RATIO_W'(1) : r;
  endfunction

  // Value loaded into the down counter: effective ratio minus one.
  function automatic logic [RATIO_W-1:0] load_of(input logic [RATIO_W-1:0] r);
    return eff_ratio(r) - RATIO_W'(1);
  endfunction
endpackage

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  input  logic          hold,
  output logic          tc
);
  localparam logic [RW-1:0] ZERO = '0;

  logic [RW-1:0] cnt_q;
  logic          run_q;
  logic [RW-1:0] load_v;

  assign load_v = RW'(load_of(RATIO_W'(ratio)));
  assign tc     = run_q && (cnt_q == ZERO);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= ZERO;
    end else if (hold) begin
      run_q <= 1'b0;
      cnt_q <= load_v;
    end else if (!run_q) begin
      run_q <= 1'b1;
      cnt_q <= load_v;
    end else if (cnt_q == ZERO) begin
      cnt_q <= load_v;
    end else begin
      cnt_q <= cnt_q - RW'(1);
    end
  end

  // R6: while running, the count only steps down by one between reloads
  p_cnt_step_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_q && !hold && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - RW'(1)));

  // R3: a reload never takes a value at or above the effective ratio
  p_reload_bound_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tc && !hold) |=> (cnt_q < RW'(eff_ratio(RATIO_W'($past(ratio))))));

  // R4: holding keeps the terminal event away in the next cycle
  p_hold_no_tc_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    hold |=> !tc);
endmodule

// File: rtl/refdiv_shape.sv
module refdiv_shape (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic tc,
  input  logic hold,
  input  logic half_en,
  output logic cmp_clk,
  output logic cmp_pulse
);
  logic tff_q;
  logic dir_q;
  logic pulse_q;
  logic rise_ev;

  // event that starts an output period in the selected mode
  assign rise_ev = half_en ? (tc && !tff_q) : tc;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      tff_q   <= 1'b0;
      dir_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (hold) begin
      tff_q   <= 1'b0;
      dir_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (tc && half_en) tff_q <= ~tff_q;
      dir_q   <= tc;
      pulse_q <= rise_ev;
    end
  end

  assign cmp_clk   = half_en ? tff_q : dir_q;
  assign cmp_pulse = pulse_q;

  // R2: each terminal count flips the toggle stage in half-rate mode
  p_tff_flip_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tc && half_en && !hold) |=> (tff_q != $past(tff_q)));

  // R5: hold or power-down leaves the toggle stage cleared
  p_tff_clear_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    hold |=> !tff_q);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  input  logic          half_en,
  input  logic          cnt_hold,
  input  logic          pwr_dn,
  output logic          cmp_clk,
  output logic          cmp_pulse
);
  logic hold;
  logic tc;

  assign hold = cnt_hold || pwr_dn;

  refdiv_count #(.RW(RW)) u_count (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .ratio   (ratio),
    .hold    (hold),
    .tc      (tc)
  );

  refdiv_shape u_shape (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .tc        (tc),
    .hold      (hold),
    .half_en   (half_en),
    .cmp_clk   (cmp_clk),
    .cmp_pulse (cmp_pulse)
  );

  // R4 / R5: a held divider is silent on the next edge
  p_hold_quiet_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    hold |=> (!cmp_clk && !cmp_pulse));

  // R7: the event pulse only appears with the clock high
  p_pulse_high_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse |-> cmp_clk);

  // R7: in half-rate mode the pulse lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (half_en && $past(half_en) && cmp_pulse) |=> !cmp_pulse);
endmodule

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] ratio = 10'd1;
  logic       half_en = 1'b0;
  logic       cnt_hold = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       cmp_clk;
  logic       cmp_pulse;

  int errors = 0;
  int checks = 0;

  always #5 clk_ref = ~clk_ref;

  refdiv_top u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio(ratio), .half_en(half_en),
    .cnt_hold(cnt_hold), .pwr_dn(pwr_dn), .cmp_clk(cmp_clk), .cmp_pulse(cmp_pulse)
  );

  // {ratio, half_en, period, high cycles}
  typedef struct packed {
    logic [9:0] r;
    logic       h;
    int         per;
    int         hi;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{10'd1,    1'b0, 1,    1},
    '{10'd0,    1'b0, 1,    1},
    '{10'd5,    1'b0, 5,    1},
    '{10'd3,    1'b0, 3,    1},
    '{10'd1023, 1'b0, 1023, 1},
    '{10'd1,    1'b1, 2,    1},
    '{10'd0,    1'b1, 2,    1},
    '{10'd4,    1'b1, 8,    4},
    '{10'd7,    1'b1, 14,   7},
    '{10'd1023, 1'b1, 2046, 1023}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // negedges from now until cmp_pulse is seen
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_ref);
      n++;
    end while (!cmp_pulse && n < 5000);
  endtask

  // called right after a pulse: cycles to next pulse and high samples
  task automatic measure(output int n, output int h);
    n = 0;
    h = 0;
    do begin
      @(negedge clk_ref);
      n++;
      if (cmp_clk) h++;
    end while (!cmp_pulse && n < 5000);
  endtask

  task automatic hold_release(input logic [9:0] r, input logic h);
    @(negedge clk_ref);
    cnt_hold = 1'b1;
    ratio = r;
    half_en = h;
    repeat (2) @(negedge clk_ref);
    cnt_hold = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, h, lat, eff;
    // R8: reset state
    repeat (3) @(negedge clk_ref);
    check("R8 clk in reset", int'(cmp_clk), 0);
    check("R8 pulse in reset", int'(cmp_pulse), 0);
    rst_n = 1'b1;

    // vector table walk: R1, R2, R3, R4 latency
    for (int i = 0; i < NV; i++) begin
      eff = (VT[i].r == 10'd0) ? 1 : int'(VT[i].r);
      hold_release(VT[i].r, VT[i].h);
      wait_pulse(lat);
      check(VT[i].r == 0 ? "R3 latency" : "R4 latency", lat, eff + 1);
      measure(n, h);
      check(VT[i].h ? "R2 period" : "R1 period", n, VT[i].per);
      check(VT[i].h ? "R2 high" : "R1 high", h, VT[i].hi);
      if (VT[i].h) begin
        measure(n, h);
        check("R2 second period", n, VT[i].per);
      end
    end

    // R4: hold keeps outputs silent
    @(negedge clk_ref);
    ratio = 10'd2; half_en = 1'b0; cnt_hold = 1'b1;
    @(negedge clk_ref);
    h = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_ref);
      if (cmp_clk || cmp_pulse) h++;
    end
    check("R4 silent while held", h, 0);
    cnt_hold = 1'b0;

    // R7: pulse width in direct mode ratio 6
    hold_release(10'd6, 1'b0);
    wait_pulse(lat);
    @(negedge clk_ref);
    check("R7 pulse one cycle", int'(cmp_pulse), 0);

    // R5: power-down while toggle output high
    hold_release(10'd5, 1'b1);
    wait_pulse(lat);
    check("R5 clk high before pd", int'(cmp_clk), 1);
    pwr_dn = 1'b1;
    @(negedge clk_ref);
    check("R5 toggle cleared", int'(cmp_clk), 0);
    repeat (4) @(negedge clk_ref);
    pwr_dn = 1'b0;
    wait_pulse(lat);
    check("R5 resume latency", lat, 6);
    measure(n, h);
    check("R5 settings kept", n, 10);

    // R6: ratio change right after an event
    hold_release(10'd10, 1'b0);
    wait_pulse(lat);
    ratio = 10'd3;
    measure(n, h);
    check("R6 running period kept", n, 10);
    measure(n, h);
    check("R6 new ratio applied", n, 3);

    // R8: async reset mid-run
    hold_release(10'd1, 1'b0);
    repeat (4) @(negedge clk_ref);
    rst_n = 1'b0;
    #1;
    check("R8 async reset clears", int'(cmp_clk) + int'(cmp_pulse), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule